// File: doc/BRIEF.md
# Out-of-Order Reservation Station Pool

This block holds instructions that have left dispatch but are still waiting for source operands. Each slot keeps an operation code, a destination tag and two source operands. Each operand has a producer tag, a data word and a valid flag. Every slot watches a tagged result broadcast. When a broadcast tag matches a source that is still waiting, that source takes the value and becomes valid.

Arrival order does not govern issue. Any slot whose two operands are valid is a candidate. When several slots are candidates, the one dispatched earliest is sent first. The chosen instruction moves into a registered issue stage, and its slot is released in the same clock. The issue stage offers the instruction to a functional unit under a valid/ready handshake and keeps it until the unit takes it. Dispatch is accepted only while at least one slot is free.

Top module: `rs_pool`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `iss_valid` is low and `disp_ready` is high, because no slot is held.
- R2: When `disp_valid` and `disp_ready` are both high at a rising edge, a free slot takes `disp_op`, `disp_dst` and both sources. A source flag of 1 means its data is already valid.
- R3: A broadcast (`bc_valid` high) sets data to `bc_data` and the valid flag to 1 on every still-invalid source of a held slot whose tag equals `bc_tag`. Sources that are already valid keep their data.
- R4: A source dispatched with flag 0 in the same cycle as a broadcast of its tag is stored valid, with `bc_data`.
- R5: A held slot is a candidate once both of its operands are valid. A later slot that becomes a candidate first issues ahead of an earlier slot that is still waiting.
- R6: When several slots are candidates, the one accepted at dispatch earliest is selected.
- R7: A slot selected at a rising edge appears at the next cycle with `iss_valid` high, carrying `iss_op`, `iss_dst`, `iss_a` (source 1 data) and `iss_b` (source 2 data). Its slot is free from that same edge. At most one slot is selected per edge, and only when the issue stage is empty or `fu_ready` is high.
- R8: While `iss_valid` is high and `fu_ready` is low, all issue outputs keep their values.
- R9: `disp_ready` is low exactly when all `ENTRIES` slots are held. A dispatch offered while it is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_ready | output | 1 | A slot is free |
| disp_op | input | OP_W | Operation code |
| disp_dst | input | TAG_W | Destination tag |
| disp_src1_tag | input | TAG_W | Producer tag of source 1 |
| disp_src1_data | input | DATA_W | Source 1 value when already valid |
| disp_src1_ok | input | 1 | Source 1 already valid |
| disp_src2_tag | input | TAG_W | Producer tag of source 2 |
| disp_src2_data | input | DATA_W | Source 2 value when already valid |
| disp_src2_ok | input | 1 | Source 2 already valid |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_data | input | DATA_W | Broadcast value |
| iss_valid | output | 1 | Issue stage holds an instruction |
| fu_ready | input | 1 | Functional unit accepts this cycle |
| iss_op | output | OP_W | Issued operation code |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_a | output | DATA_W | Issued source 1 value |
| iss_b | output | DATA_W | Issued source 2 value |

## Verification
The directed patterns cover several cases. One is an instruction with both operands ready, which shows the two-edge path from dispatch to issue. Another pairs a waiting slot with a later ready one, which separates out-of-order issue from FIFO issue. A third dispatches several ready slots behind a stalled unit, which exposes the age ordering among candidates.

A dispatch that meets the broadcast of its own tag catches a missing bypass. A pool filled with slots waiting on a tag that never arrives exercises refusal at full, then the drain when the tag finally comes. A long random mix of dispatch, broadcast and unit back-pressure is then checked every clock against a behavioural model that orders slots by an unbounded sequence count.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int OP_W   = 4;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
    logic              ok;
  } src_t;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] dst;
    src_t             s1;
    src_t             s2;
  } slot_t;

  // Operand as stored at dispatch, taking a same-cycle broadcast into account.
  function automatic src_t merge_src(input logic [TAG_W-1:0] tag,
                                     input logic [DATA_W-1:0] data,
                                     input logic ok,
                                     input logic bcv,
                                     input logic [TAG_W-1:0] bct,
                                     input logic [DATA_W-1:0] bcd);
    src_t r;
    r.tag  = tag;
    r.data = data;
    r.ok   = ok;
    if (!ok && bcv && (bct == tag)) begin
      r.data = bcd;
      r.ok   = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_slot.sv
module rs_slot import rs_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  slot_t             load_data,
  input  logic              clear,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              held,
  output logic              ready,
  output slot_t             q
);
  logic  held_q;
  slot_t slot_q;

  always_ff @(posedge clk) begin
    if (rst)        held_q <= 1'b0;
    else if (load)  held_q <= 1'b1;
    else if (clear) held_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (load) begin
      slot_q <= load_data;
    end else if (held_q && bc_valid) begin
      if (!slot_q.s1.ok && (slot_q.s1.tag == bc_tag)) begin
        slot_q.s1.data <= bc_data;
        slot_q.s1.ok   <= 1'b1;
      end
      if (!slot_q.s2.ok && (slot_q.s2.tag == bc_tag)) begin
        slot_q.s2.data <= bc_data;
        slot_q.s2.ok   <= 1'b1;
      end
    end
  end

  assign held  = held_q;
  assign ready = held_q && slot_q.s1.ok && slot_q.s2.ok;
  assign q     = slot_q;
endmodule

// File: rtl/rs_age.sv
// Relative-age matrix: bit (i*N + j) set means slot i was dispatched before slot j.
module rs_age #(
  parameter int ENTRIES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ENTRIES-1:0]         alloc,
  output logic [ENTRIES*ENTRIES-1:0] older
);
  logic [ENTRIES*ENTRIES-1:0] older_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (i != j) begin
            if (alloc[i])      older_q[i*ENTRIES+j] <= 1'b0;
            else if (alloc[j]) older_q[i*ENTRIES+j] <= 1'b1;
          end
        end
      end
    end
  end

  assign older = older_q;
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0]         ready,
  input  logic [ENTRIES*ENTRIES-1:0] older,
  output logic [ENTRIES-1:0]         grant,
  output logic                       any
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_pick
    logic [ENTRIES-1:0] blockers;
    for (genvar j = 0; j < ENTRIES; j++) begin : g_cmp
      if (i == j) begin : g_self
        assign blockers[j] = 1'b0;
      end else begin : g_other
        assign blockers[j] = ready[j] && older[j*ENTRIES+i];
      end
    end
    assign grant[i] = ready[i] && !(|blockers);
  end
  assign any = |ready;
endmodule

// File: rtl/rs_pool.sv
module rs_pool import rs_pkg::*; #(
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [OP_W-1:0]   disp_op,
  input  logic [TAG_W-1:0]  disp_dst,
  input  logic [TAG_W-1:0]  disp_src1_tag,
  input  logic [DATA_W-1:0] disp_src1_data,
  input  logic              disp_src1_ok,
  input  logic [TAG_W-1:0]  disp_src2_tag,
  input  logic [DATA_W-1:0] disp_src2_data,
  input  logic              disp_src2_ok,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              iss_valid,
  input  logic              fu_ready,
  output logic [OP_W-1:0]   iss_op,
  output logic [TAG_W-1:0]  iss_dst,
  output logic [DATA_W-1:0] iss_a,
  output logic [DATA_W-1:0] iss_b
);
  localparam int AGE_BITS = ENTRIES * ENTRIES;

  logic [ENTRIES-1:0]  held_vec, ready_vec, grant_vec, alloc_vec, load_vec, clear_vec;
  logic [AGE_BITS-1:0] older;
  slot_t               slot_q [ENTRIES];
  slot_t               disp_slot, pick_slot;
  logic                disp_fire, out_free, any_ready, take;
  logic                iss_valid_q;
  logic [OP_W-1:0]     iss_op_q;
  logic [TAG_W-1:0]    iss_dst_q;
  logic [DATA_W-1:0]   iss_a_q, iss_b_q;

  always_comb begin
    disp_slot.op  = disp_op;
    disp_slot.dst = disp_dst;
    disp_slot.s1  = merge_src(disp_src1_tag, disp_src1_data, disp_src1_ok, bc_valid, bc_tag, bc_data);
    disp_slot.s2  = merge_src(disp_src2_tag, disp_src2_data, disp_src2_ok, bc_valid, bc_tag, bc_data);
  end

  // Lowest-numbered free slot receives the next dispatch.
  always_comb begin
    alloc_vec = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!held_vec[i]) begin
        alloc_vec    = '0;
        alloc_vec[i] = 1'b1;
      end
    end
  end

  assign disp_ready = ~&held_vec;
  assign disp_fire  = disp_valid && disp_ready;
  assign load_vec   = alloc_vec & {ENTRIES{disp_fire}};
  assign out_free   = !iss_valid_q || fu_ready;
  assign take       = out_free && any_ready;
  assign clear_vec  = grant_vec & {ENTRIES{take}};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    rs_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .load      (load_vec[g]),
      .load_data (disp_slot),
      .clear     (clear_vec[g]),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_data   (bc_data),
      .held      (held_vec[g]),
      .ready     (ready_vec[g]),
      .q         (slot_q[g])
    );
  end

  rs_age #(.ENTRIES(ENTRIES)) u_age (
    .clk   (clk),
    .rst   (rst),
    .alloc (load_vec),
    .older (older)
  );

  rs_select #(.ENTRIES(ENTRIES)) u_sel (
    .ready (ready_vec),
    .older (older),
    .grant (grant_vec),
    .any   (any_ready)
  );

  always_comb begin
    pick_slot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant_vec[i]) pick_slot = pick_slot | slot_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           iss_valid_q <= 1'b0;
    else if (out_free) iss_valid_q <= take;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      iss_op_q  <= pick_slot.op;
      iss_dst_q <= pick_slot.dst;
      iss_a_q   <= pick_slot.s1.data;
      iss_b_q   <= pick_slot.s2.data;
    end
  end

  assign iss_valid = iss_valid_q;
  assign iss_op    = iss_op_q;
  assign iss_dst   = iss_dst_q;
  assign iss_a     = iss_a_q;
  assign iss_b     = iss_b_q;
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk import rs_pkg::*; #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               disp_ready,
  input logic               fu_ready,
  input logic               iss_valid,
  input logic [OP_W-1:0]    iss_op,
  input logic [TAG_W-1:0]   iss_dst,
  input logic [DATA_W-1:0]  iss_a,
  input logic [DATA_W-1:0]  iss_b,
  input logic [ENTRIES-1:0] held,
  input logic [ENTRIES-1:0] grant
);
  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> (!iss_valid && disp_ready));

  assert_single_grant_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_issues_R7: assert property (@(posedge clk) disable iff (rst)
    ((grant != '0) && (!iss_valid || fu_ready)) |=> iss_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !fu_ready) |=> (iss_valid && $stable(iss_op) && $stable(iss_dst)
                                  && $stable(iss_a) && $stable(iss_b)));

  assert_full_refuse_R9: assert property (@(posedge clk) disable iff (rst)
    !disp_ready |=> ($countones(held) >= ENTRIES - 1));
endmodule

bind rs_pool rs_pool_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .disp_ready (disp_ready),
  .fu_ready   (fu_ready),
  .iss_valid  (iss_valid),
  .iss_op     (iss_op),
  .iss_dst    (iss_dst),
  .iss_a      (iss_a),
  .iss_b      (iss_b),
  .held       (held_vec),
  .grant      (grant_vec)
);

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
  import rs_pkg::*;
  localparam int  E      = 4;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b1;
  logic disp_valid = 0, disp_src1_ok = 0, disp_src2_ok = 0, bc_valid = 0, fu_ready = 1;
  logic [OP_W-1:0]   disp_op = 0;
  logic [TAG_W-1:0]  disp_dst = 0, disp_src1_tag = 0, disp_src2_tag = 0, bc_tag = 0;
  logic [DATA_W-1:0] disp_src1_data = 0, disp_src2_data = 0, bc_data = 0;
  logic              disp_ready, iss_valid;
  logic [OP_W-1:0]   iss_op;
  logic [TAG_W-1:0]  iss_dst;
  logic [DATA_W-1:0] iss_a, iss_b;

  always #(PERIOD/2) clk = ~clk;

  rs_pool #(.ENTRIES(E)) dut (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_op(disp_op), .disp_dst(disp_dst),
    .disp_src1_tag(disp_src1_tag), .disp_src1_data(disp_src1_data), .disp_src1_ok(disp_src1_ok),
    .disp_src2_tag(disp_src2_tag), .disp_src2_data(disp_src2_data), .disp_src2_ok(disp_src2_ok),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .iss_valid(iss_valid), .fu_ready(fu_ready),
    .iss_op(iss_op), .iss_dst(iss_dst), .iss_a(iss_a), .iss_b(iss_b)
  );

  // Behavioural reference: unordered slots, age by an ever-growing sequence count.
  bit     m_held [E];
  int     m_seq  [E];
  int     m_op [E], m_dst [E], m_t1 [E], m_d1 [E], m_t2 [E], m_d2 [E];
  bit     m_v1 [E], m_v2 [E];
  bit     m_iv;
  int     m_oop, m_odst, m_oa, m_ob;
  int     seq_ctr = 0;
  int     checks = 0, fails = 0;
  bit     done = 0;
  string  cur_req = "R1";

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < E; i++) if (m_held[i]) c++;
    return c;
  endfunction

  task automatic model_update();
    int  pick;
    bit  acc;
    if (rst) begin
      for (int i = 0; i < E; i++) m_held[i] = 0;
      m_iv = 0;
      return;
    end
    acc  = disp_valid && (m_count() < E);
    pick = -1;
    if (!m_iv || fu_ready) begin
      for (int i = 0; i < E; i++)
        if (m_held[i] && m_v1[i] && m_v2[i] && (pick < 0 || m_seq[i] < m_seq[pick])) pick = i;
      m_iv = (pick >= 0);
      if (pick >= 0) begin
        m_oop = m_op[pick]; m_odst = m_dst[pick]; m_oa = m_d1[pick]; m_ob = m_d2[pick];
        m_held[pick] = 0;
      end
    end
    if (bc_valid) begin
      for (int i = 0; i < E; i++) begin
        if (m_held[i] && !m_v1[i] && m_t1[i] == int'(bc_tag)) begin m_v1[i] = 1; m_d1[i] = int'(bc_data); end
        if (m_held[i] && !m_v2[i] && m_t2[i] == int'(bc_tag)) begin m_v2[i] = 1; m_d2[i] = int'(bc_data); end
      end
    end
    if (acc) begin
      for (int i = 0; i < E; i++) begin
        if (!m_held[i]) begin
          m_held[i] = 1; m_seq[i] = seq_ctr; seq_ctr++;
          m_op[i] = int'(disp_op); m_dst[i] = int'(disp_dst);
          m_t1[i] = int'(disp_src1_tag); m_t2[i] = int'(disp_src2_tag);
          m_v1[i] = disp_src1_ok || (bc_valid && bc_tag == disp_src1_tag);
          m_d1[i] = disp_src1_ok ? int'(disp_src1_data) : (m_v1[i] ? int'(bc_data) : 0);
          m_v2[i] = disp_src2_ok || (bc_valid && bc_tag == disp_src2_tag);
          m_d2[i] = disp_src2_ok ? int'(disp_src2_data) : (m_v2[i] ? int'(bc_data) : 0);
          break;
        end
      end
    end
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(disp_ready == (m_count() < E), "disp_ready", int'(disp_ready), int'(m_count() < E));
    chk(iss_valid == m_iv, "iss_valid", int'(iss_valid), int'(m_iv));
    if (m_iv && iss_valid) begin
      chk(int'(iss_op) == m_oop,   "iss_op",  int'(iss_op),  m_oop);
      chk(int'(iss_dst) == m_odst, "iss_dst", int'(iss_dst), m_odst);
      chk(int'(iss_a) == m_oa,     "iss_a",   int'(iss_a),   m_oa);
      chk(int'(iss_b) == m_ob,     "iss_b",   int'(iss_b),   m_ob);
    end
  endtask

  // Inputs already set at a falling edge; advance one clock and compare.
  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    if (!rst) compare();
  endtask

  task automatic disp(input int op, input int dst, input int t1, input int d1, input bit k1,
                      input int t2, input int d2, input bit k2);
    disp_valid = 1; disp_op = OP_W'(op); disp_dst = TAG_W'(dst);
    disp_src1_tag = TAG_W'(t1); disp_src1_data = DATA_W'(d1); disp_src1_ok = k1;
    disp_src2_tag = TAG_W'(t2); disp_src2_data = DATA_W'(d2); disp_src2_ok = k2;
  endtask

  task automatic bcast(input bit v, input int t, input int d);
    bc_valid = v; bc_tag = TAG_W'(t); bc_data = DATA_W'(d);
  endtask

  task automatic idle(input int n);
    disp_valid = 0; bc_valid = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    rst = 1; step(); step();
    rst = 0;
    cur_req = "R1"; disp_valid = 0;
    step();
    chk(disp_ready == 1'b1, "reset disp_ready", int'(disp_ready), 1);
    chk(iss_valid == 1'b0, "reset iss_valid", int'(iss_valid), 0);

    // R2 / R7: ready instruction reaches the issue stage on the second edge
    cur_req = "R2"; fu_ready = 1;
    disp(3, 5, 1, 'h11, 1, 2, 'h22, 1); step();
    disp_valid = 0; cur_req = "R7"; step();
    chk(iss_valid && iss_a == 16'h11 && iss_b == 16'h22, "R7 issue payload", int'(iss_a), 'h11);
    idle(2);

    // R5 / R3: younger ready slot overtakes an older waiting one
    cur_req = "R5";
    disp(1, 7, 2, 0, 0, 3, 'h33, 1); step();
    disp(2, 8, 4, 'h44, 1, 5, 'h55, 1); step();
    disp_valid = 0; step();
    chk(iss_valid && iss_op == 4'd2, "R5 younger first", int'(iss_op), 2);
    cur_req = "R3";
    bcast(1, 2, 'hAB); step(); bcast(0, 0, 0); step();
    chk(iss_valid && iss_op == 4'd1 && iss_a == 16'hAB, "R3 captured value", int'(iss_a), 'hAB);
    idle(2);

    // R4: dispatch meets the broadcast of its own tag
    cur_req = "R4";
    disp(4, 9, 6, 0, 0, 6, 0, 0); bcast(1, 6, 'h77); step();
    disp_valid = 0; bcast(0, 0, 0); step();
    chk(iss_valid && iss_a == 16'h77 && iss_b == 16'h77, "R4 bypass", int'(iss_b), 'h77);
    idle(2);

    // R6 / R8: three ready slots behind a stalled unit leave in dispatch order
    cur_req = "R8"; fu_ready = 0;
    disp(5, 1, 0, 1, 1, 0, 1, 1); step();
    disp(6, 2, 0, 2, 1, 0, 2, 1); step();
    disp(7, 3, 0, 3, 1, 0, 3, 1); step();
    disp_valid = 0; step(); step();
    chk(iss_valid && iss_op == 4'd5, "R8 held under stall", int'(iss_op), 5);
    cur_req = "R6"; fu_ready = 1;
    step(); chk(iss_op == 4'd6, "R6 second oldest", int'(iss_op), 6);
    step(); chk(iss_op == 4'd7, "R6 third oldest", int'(iss_op), 7);
    idle(2);

    // R9: fill with slots waiting on a tag that is not broadcast, then drain
    cur_req = "R9";
    for (int i = 0; i < E + 2; i++) begin
      disp(8 + (i % 8), i, 9, 0, 0, 1, i, 1); step();
    end
    chk(disp_ready == 1'b0, "R9 full", int'(disp_ready), 0);
    disp_valid = 0; bcast(1, 9, 'h99); step(); bcast(0, 0, 0);
    idle(E + 3);
    chk(disp_ready == 1'b1, "R9 drained", int'(disp_ready), 1);

    // Random mix, compared every clock
    cur_req = "R3";
    for (int c = 0; c < 3000; c++) begin
      disp_valid = ($urandom_range(9, 0) < 7);
      disp_op = OP_W'($urandom); disp_dst = TAG_W'($urandom);
      disp_src1_tag = TAG_W'($urandom_range(7, 1)); disp_src1_data = DATA_W'($urandom);
      disp_src1_ok = $urandom_range(1, 0) == 1;
      disp_src2_tag = TAG_W'($urandom_range(7, 1)); disp_src2_data = DATA_W'($urandom);
      disp_src2_ok = $urandom_range(1, 0) == 1;
      bcast($urandom_range(9, 0) < 4, int'($urandom_range(7, 1)), int'($urandom_range(65535, 0)));
      fu_ready = ($urandom_range(9, 0) < 7);
      step();
    end
    fu_ready = 1;
    idle(4);
    finish_run();
  end
endmodule